// File: doc/BRIEF.md
# Flash Buffered-Write Command Sequencer

This block is the command front end of a parallel NOR flash for buffered programming. A host sends a series of bus writes: a setup opcode, a word count given as N-1, N data words that fill an internal buffer, and a confirm opcode. The confirm starts a write state machine. It copies the buffer into a small on-chip array at one word per clock. Programming can only clear bits, so each stored word becomes the AND of its old value and the new data.

Before any word is written, the sequencer checks the request. A missing confirm, a count above the buffer depth, a range that crosses an erase block, a missing program voltage and a locked target block each set their own combination of status bits. After any such fault, no array word changes. While a sequence or program-fail error stays latched, new setup commands are refused until a clear-status command arrives. A read mode selects whether the data output shows the array or the status byte.

Top module: `fbw_seq`

## Requirements
- R1: After reset, status reads 0x80, busy is 0, the buffer-available flag is 1, every array word reads 0xFFFF, and the data output shows the array.
- R2: Writing setup (0xE8), a count C in 0..15, C+1 data words and confirm (0xD0) raises busy for exactly C+1 cycles, starting at the clock edge that takes the confirm. While busy is high, status bit 7 is 0. Word i goes to address start+i, where start is the address of the first data write.
- R3: If any byte other than 0xD0 follows the last data word, status bits 5 and 4 are set (status 0xB0) and the array is unchanged.
- R4: A count value greater than 15 sets status bits 5 and 4 (0xB0) and ends the sequence.
- R5: A range whose first and last words lie in different 32-word blocks sets bits 5 and 4 (0xB0), and nothing is programmed.
- R6: While bit 4 or bit 5 is set, a setup command is ignored. The later count, data and confirm writes then program nothing. A clear-status command (0x50) returns status to 0x80.
- R7: If the voltage-valid input is low at confirm, bits 4 and 3 are set (0x98) and nothing is programmed.
- R8: If the lock input bit of the target block (block = address bits 6:5) is set at confirm, bits 4 and 1 are set (0x92) and nothing is programmed.
- R9: A programmed word becomes old AND data. Programming never sets a bit that was 0.
- R10: Command 0x70 or 0xE8 makes the data output show {8'h00, status}. Command 0xFF makes it show the array word at the read address.
- R11: The buffer-available flag is 1 only when the sequencer is idle and neither bit 4 nor bit 5 is set.
- R12: When several faults apply at confirm, they are ranked as follows: a block crossing first, then voltage, then lock. Only the highest-ranked fault is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | 7 | Bus write address |
| wr_data | input | 16 | Bus write data; commands use the low byte |
| vpp_ok | input | 1 | Program voltage valid |
| blk_lock | input | 4 | Lock bit per 32-word block |
| rd_addr | input | 7 | Array read address |
| status | output | 8 | Status byte: 7 ready, 5 sequence error, 4 program fail, 3 voltage fault, 1 lock fault |
| xsr_avail | output | 1 | Buffer available for a new buffered write |
| busy | output | 1 | Write state machine is copying |
| dout | output | 16 | Array word or status, per read mode |

## Verification
Every command takes effect at the clock edge that samples the write. Status, the buffer-available flag and the read mode therefore change one edge after the write, and the bench reads them at the next falling edge. Busy rises at the confirm edge and stays high for exactly count+1 cycles. The bench counts those cycles on falling edges and checks status and array contents only after busy drops. Array reads are combinational, so a read-address change is sampled in the same half cycle.

// File: rtl/fbw_pkg.sv
package fbw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_COUNT, ST_LOAD, ST_CONFIRM, ST_PROG
  } seq_st_t;

  localparam logic [7:0] OP_SETUP   = 8'hE8;
  localparam logic [7:0] OP_CONFIRM = 8'hD0;
  localparam logic [7:0] OP_CLEAR   = 8'h50;
  localparam logic [7:0] OP_RDSTAT  = 8'h70;
  localparam logic [7:0] OP_RDARR   = 8'hFF;

  // True when first and last word fall in different erase blocks.
  function automatic logic spans_blocks(input int unsigned first_w,
                                        input int unsigned last_w,
                                        input int unsigned blk_bits);
    return (first_w >> blk_bits) != (last_w >> blk_bits);
  endfunction
endpackage

// File: rtl/fbw_buffer.sv
module fbw_buffer #(
  parameter int DW    = 16,
  parameter int DEPTH = 16,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] ridx,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] slot [DEPTH];

  always_ff @(posedge clk) begin
    if (we) slot[widx] <= wdata;
  end

  assign rdata = slot[ridx];
endmodule

// File: rtl/fbw_array.sv
module fbw_array #(
  parameter int DW = 16,
  parameter int AW = 7,
  localparam int WORDS = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prog_en,
  input  logic [AW-1:0] prog_addr,
  input  logic [DW-1:0] prog_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] mem [WORDS];
  logic [DW-1:0] old_word;
  logic [DW-1:0] new_word;

  // Flash programming only pulls bits low.
  function automatic logic [DW-1:0] clear_only(input logic [DW-1:0] cur,
                                               input logic [DW-1:0] dat);
    return cur & dat;
  endfunction

  assign old_word = mem[prog_addr];
  assign new_word = clear_only(old_word, prog_data);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '1;
    end else if (prog_en) begin
      mem[prog_addr] <= new_word;
    end
  end

  assign rd_data = mem[rd_addr];

  // R9: no bit that was 0 comes back as 1
  a_r9_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
    prog_en |=> ((mem[$past(prog_addr)] & ~$past(old_word)) == '0));
endmodule

// File: rtl/fbw_seq.sv
module fbw_seq #(
  parameter int DW    = 16,
  parameter int AW    = 7,
  parameter int BLK_W = 5,
  parameter int DEPTH = 16,
  localparam int NBLK = 1 << (AW - BLK_W),
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic            vpp_ok,
  input  logic [NBLK-1:0] blk_lock,
  input  logic [AW-1:0]   rd_addr,
  output logic [7:0]      status,
  output logic            xsr_avail,
  output logic            busy,
  output logic [DW-1:0]   dout
);
  import fbw_pkg::*;

  seq_st_t       st_q;
  logic [IW-1:0] cnt_q, idx_q, ptr_q;
  logic [AW-1:0] start_q;
  logic          seq_err_q, pfail_q, volt_err_q, lock_err_q;
  logic          show_arr_q;

  logic [7:0]    cmd;
  logic          err_latched;
  logic [DW-1:0] buf_rdata, arr_rdata;

  // Named events
  logic ev_setup, ev_setup_ok, ev_clear, ev_count, ev_count_bad;
  logic ev_load, ev_load_last, ev_confirm, ev_bad_op, ev_cross, ev_volt;
  logic ev_lock, ev_go, ev_fault, ev_prog_last;

  assign cmd          = wr_data[7:0];
  assign err_latched  = seq_err_q | pfail_q;
  assign ev_setup     = wr_en && st_q == ST_IDLE && cmd == OP_SETUP;
  assign ev_setup_ok  = ev_setup && !err_latched;
  assign ev_clear     = wr_en && st_q == ST_IDLE && cmd == OP_CLEAR;
  assign ev_count     = wr_en && st_q == ST_COUNT;
  assign ev_count_bad = ev_count && (wr_data > DW'(DEPTH - 1));
  assign ev_load      = wr_en && st_q == ST_LOAD;
  assign ev_load_last = ev_load && idx_q == cnt_q;
  assign ev_confirm   = wr_en && st_q == ST_CONFIRM;
  assign ev_bad_op    = ev_confirm && cmd != OP_CONFIRM;
  assign ev_cross     = ev_confirm && !ev_bad_op &&
                        spans_blocks(int'(start_q), int'(start_q) + int'(cnt_q), BLK_W);
  assign ev_volt      = ev_confirm && !ev_bad_op && !ev_cross && !vpp_ok;
  assign ev_lock      = ev_confirm && !ev_bad_op && !ev_cross && vpp_ok &&
                        blk_lock[start_q[AW-1:BLK_W]];
  assign ev_fault     = ev_bad_op || ev_cross || ev_volt || ev_lock;
  assign ev_go        = ev_confirm && !ev_fault;
  assign ev_prog_last = st_q == ST_PROG && ptr_q == cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      cnt_q      <= '0;
      idx_q      <= '0;
      ptr_q      <= '0;
      start_q    <= '0;
      seq_err_q  <= 1'b0;
      pfail_q    <= 1'b0;
      volt_err_q <= 1'b0;
      lock_err_q <= 1'b0;
      show_arr_q <= 1'b1;
    end else begin
      if (wr_en && st_q == ST_IDLE) begin
        if (cmd == OP_RDARR) show_arr_q <= 1'b1;
        if (cmd == OP_RDSTAT || cmd == OP_SETUP) show_arr_q <= 1'b0;
      end
      if (ev_clear) begin
        seq_err_q  <= 1'b0;
        pfail_q    <= 1'b0;
        volt_err_q <= 1'b0;
        lock_err_q <= 1'b0;
      end
      if (ev_setup_ok) st_q <= ST_COUNT;
      if (ev_count) begin
        if (ev_count_bad) begin
          seq_err_q <= 1'b1;
          pfail_q   <= 1'b1;
          st_q      <= ST_IDLE;
        end else begin
          cnt_q <= wr_data[IW-1:0];
          idx_q <= '0;
          st_q  <= ST_LOAD;
        end
      end
      if (ev_load) begin
        if (idx_q == '0) start_q <= wr_addr;
        idx_q <= idx_q + 1'b1;
        if (ev_load_last) st_q <= ST_CONFIRM;
      end
      if (ev_confirm) begin
        if (ev_bad_op || ev_cross) seq_err_q <= 1'b1;
        if (ev_fault) pfail_q <= 1'b1;
        if (ev_volt) volt_err_q <= 1'b1;
        if (ev_lock) lock_err_q <= 1'b1;
        ptr_q <= '0;
        st_q  <= ev_go ? ST_PROG : ST_IDLE;
      end
      if (st_q == ST_PROG) begin
        ptr_q <= ptr_q + 1'b1;
        if (ev_prog_last) st_q <= ST_IDLE;
      end
    end
  end

  fbw_buffer #(.DW(DW), .DEPTH(DEPTH)) u_buf (
    .clk   (clk),
    .we    (ev_load),
    .widx  (idx_q),
    .wdata (wr_data),
    .ridx  (ptr_q),
    .rdata (buf_rdata)
  );

  fbw_array #(.DW(DW), .AW(AW)) u_arr (
    .clk       (clk),
    .rst_n     (rst_n),
    .prog_en   (st_q == ST_PROG),
    .prog_addr (start_q + AW'(ptr_q)),
    .prog_data (buf_rdata),
    .rd_addr   (rd_addr),
    .rd_data   (arr_rdata)
  );

  assign busy      = st_q == ST_PROG;
  assign status    = {!busy, 1'b0, seq_err_q, pfail_q, volt_err_q, 1'b0, lock_err_q, 1'b0};
  assign xsr_avail = st_q == ST_IDLE && !err_latched;
  assign dout      = show_arr_q ? arr_rdata : {{(DW-8){1'b0}}, status};

  // R3 R4 R5: a sequence error always comes with program fail
  a_r3_seq_implies_fail: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err_q |-> pfail_q);
  // R7 R8: voltage or lock fault always comes with program fail
  a_r7_fault_implies_fail: assert property (@(posedge clk) disable iff (!rst_n)
    (volt_err_q || lock_err_q) |-> pfail_q);
  // R6: setup refused while an error is latched
  a_r6_setup_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_setup && err_latched) |=> st_q == ST_IDLE);
  // R2: copy pointer never passes the count
  a_r2_ptr_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ptr_q <= cnt_q);
  // R5 R7 R8: a faulted confirm never starts programming
  a_r8_fault_no_prog: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fault |=> !busy);
  // R12: exactly one fault cause per confirm
  a_r12_one_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_bad_op, ev_cross, ev_volt, ev_lock}));
endmodule

// File: tb/sim_fbw_seq.sv
module sim_fbw_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [6:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        vpp_ok = 1'b1;
  logic [3:0]  blk_lock = '0;
  logic [6:0]  rd_addr = '0;
  logic [7:0]  status;
  logic        xsr_avail, busy;
  logic [15:0] dout;

  int total = 0;
  int bad = 0;
  logic [15:0] model [128];

  always #10 clk = ~clk;

  fbw_seq u0 (.*);

  // fields: start[47:41] cnt[40:37] seed[36:21] vpp[20] lock[19:16] op[15:8] exp[7:0]
  localparam int NV = 10;
  localparam logic [47:0] VEC [NV] = '{
    {7'd0,   4'd3,  16'hA5A5, 1'b1, 4'b0000, 8'hD0, 8'h80}, // R2
    {7'd2,   4'd1,  16'h0F0F, 1'b1, 4'b0000, 8'hD0, 8'h80}, // R9 overlap
    {7'd40,  4'd15, 16'h1234, 1'b1, 4'b0000, 8'hD0, 8'h80}, // R2 full depth
    {7'd20,  4'd15, 16'h5555, 1'b1, 4'b0000, 8'hD0, 8'hB0}, // R5
    {7'd64,  4'd2,  16'h00FF, 1'b0, 4'b0000, 8'hD0, 8'h98}, // R7
    {7'd70,  4'd2,  16'h0000, 1'b1, 4'b0100, 8'hD0, 8'h92}, // R8
    {7'd10,  4'd0,  16'h0000, 1'b1, 4'b0000, 8'h70, 8'hB0}, // R3
    {7'd30,  4'd3,  16'h0000, 1'b0, 4'b0001, 8'hD0, 8'hB0}, // R12
    {7'd100, 4'd0,  16'h3C3C, 1'b1, 4'b0100, 8'hD0, 8'h80}, // R8 other block
    {7'd127, 4'd0,  16'h7E7E, 1'b1, 4'b0000, 8'hD0, 8'h80}  // R2 last word
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [15:0] word_of(input logic [15:0] seed, input int i);
    return seed ^ (16'h1111 * 16'(i));
  endfunction

  task automatic array_check(input string req);
    int mism = -1;
    wr(7'd0, 16'h00FF);
    for (int a = 0; a < 128; a++) begin
      rd_addr = 7'(a);
      #1;
      if (dout !== model[a] && mism < 0) mism = a;
    end
    if (mism < 0) chk(1'b1, req, 0, 0);
    else begin
      rd_addr = 7'(mism); #1;
      chk(1'b0, req, int'(dout), int'(model[mism]));
    end
  endtask

  task automatic wait_busy(output int n, output bit sr7_ok);
    n = 0; sr7_ok = 1'b1;
    while (busy) begin
      if (status[7]) sr7_ok = 1'b0;
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    for (int i = 0; i < 128; i++) model[i] = 16'hFFFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(status == 8'h80, "R1 status", status, 8'h80);
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(xsr_avail == 1'b1, "R1 avail", xsr_avail, 1);
    rd_addr = 7'd5; #1;
    chk(dout == 16'hFFFF, "R1 array", dout, 16'hFFFF);

    for (int v = 0; v < NV; v++) begin
      logic [6:0] st; logic [3:0] c; logic [15:0] sd; logic [7:0] op, ex;
      int n; bit s7;
      st = VEC[v][47:41]; c = VEC[v][40:37]; sd = VEC[v][36:21];
      op = VEC[v][15:8]; ex = VEC[v][7:0];
      wr(7'd0, 16'h0050);
      vpp_ok = VEC[v][20]; blk_lock = VEC[v][19:16];
      wr(st, 16'h00E8);
      chk(xsr_avail == 1'b0, "R11 avail low in sequence", xsr_avail, 0);
      wr(st, 16'(c));
      for (int i = 0; i <= int'(c); i++) wr(i == 0 ? st : 7'd0, word_of(sd, i));
      wr(st, {8'h00, op});
      wait_busy(n, s7);
      chk(n == ((ex == 8'h80) ? int'(c) + 1 : 0), "R2 busy length", n, (ex == 8'h80) ? int'(c) + 1 : 0);
      chk(s7, "R2 ready low while busy", 0, 0);
      chk(status == ex, "R3/R5/R7/R8/R12 status", status, ex);
      if (ex == 8'h80)
        for (int i = 0; i <= int'(c); i++)
          model[7'(int'(st) + i)] = model[7'(int'(st) + i)] & word_of(sd, i);
      vpp_ok = 1'b1; blk_lock = '0;
      array_check("R2/R9 array contents");
    end

    // R4 count too large
    wr(7'd0, 16'h0050);
    wr(7'd0, 16'h00E8);
    wr(7'd0, 16'd16);
    chk(status == 8'hB0, "R4 count overflow", status, 8'hB0);
    chk(xsr_avail == 1'b0, "R11 avail low on error", xsr_avail, 0);

    // R6 setup refused while error latched
    wr(7'd50, 16'h00E8);
    wr(7'd50, 16'h0000);
    wr(7'd50, 16'h0000);
    wr(7'd50, 16'h00D0);
    chk(busy == 1'b0, "R6 no programming", busy, 0);
    chk(status == 8'hB0, "R6 status held", status, 8'hB0);
    array_check("R6 array unchanged");
    wr(7'd0, 16'h0050);
    chk(status == 8'h80, "R6 clear", status, 8'h80);
    chk(xsr_avail == 1'b1, "R11 avail after clear", xsr_avail, 1);

    // R10 read modes
    wr(7'd0, 16'h0070);
    chk(dout == 16'h0080, "R10 status mode", dout, 16'h0080);
    wr(7'd0, 16'h00FF);
    rd_addr = 7'd0; #1;
    chk(dout == model[0], "R10 array mode", dout, model[0]);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hang expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule